// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes for a network controller and presents them to a host through a small offset-decoded register window. A 32-bit cause register collects events from hardware pulse inputs and from host writes. A 32-bit mask register selects which causes drive the level interrupt line. Reading the cause register returns its value and clears it in the same access, so the host's service routine needs only one read per pass.

Receive completions need extra handling. Each receive-complete pulse sets the receive-timer cause and adds one to a saturating counter of pending packets. When a clearing read finds the counter above zero, the block sets the receive-timer cause again and takes one from the counter. The host therefore sees that cause once more for every packet still outstanding.

Host accesses are single-cycle. Read data is combinational from the current register state. Every state change takes effect at the clock edge that ends the access.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After synchronous reset, the cause register, the mask register and the pending counter are all zero, and `irq_o` is low.
- R2: A read at offset 0x0C0 returns the cause register in the same cycle. From the next cycle the register is zero, except for bits re-armed under R7 and R9.
- R3: A write at offset 0x0C8 ORs `host_wdata` into the cause register, and the change is visible from the next cycle.
- R4: A write at offset 0x0D0 ORs `host_wdata` into the mask register. A read at offset 0x0D0 returns the mask register.
- R5: A write at offset 0x0D8 clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R6: `irq_o` is high exactly when the registered cause AND the registered mask is nonzero. It follows each cause or mask change one cycle after the access or event.
- R7: A one-cycle pulse on `hw_event_i[i]` sets cause bit i. If the pulse lands in the same cycle as a clearing read, the bit is still set afterwards. Bit 0 is transmit write-back, bit 1 is transmit queue empty, bit 6 is receive overrun and bit 9 is management access done.
- R8: A pulse on `rx_done_i` sets cause bit 7 and increments the pending counter. The counter saturates at 2^CNT_W-1 (15 by default).
- R9: A clearing read made while the pending counter is nonzero leaves cause bit 7 set and decrements the counter. After N counted packets, exactly N+1 consecutive reads at 0x0C0 return bit 7 set.
- R10: Writes to 0x0C0 or to unmapped offsets change no state. Reads of 0x0C8, 0x0D8 or unmapped offsets return zero and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access in this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 12 | Byte offset of the access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid in the cycle of a read |
| hw_event_i | input | 32 | Per-bit cause set pulses |
| rx_done_i | input | 1 | Receive-complete pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a pending counter at saturation. A single receive completion followed by reads cannot tell a saturating counter from a wrapping one. The bench therefore applies more receive pulses than the counter can hold, then counts how many back-to-back clearing reads return bit 7 set. The count must equal the maximum plus one. The bench also drives a hardware event in the same cycle as a clearing read, a collision that normal traffic rarely produces.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants for the interrupt cause/mask controller.
// Assumes byte offsets narrower than 12 bits are zero-extended by the host.
package irq_ctrl_pkg;
    localparam int OFFSET_W = 12;
    localparam logic [OFFSET_W-1:0] OFF_CAUSE_RC  = 12'h0C0;
    localparam logic [OFFSET_W-1:0] OFF_CAUSE_SET = 12'h0C8;
    localparam logic [OFFSET_W-1:0] OFF_MASK_SET  = 12'h0D0;
    localparam logic [OFFSET_W-1:0] OFF_MASK_CLR  = 12'h0D8;

    // Cause bit positions fixed by the host driver
    localparam int BIT_TX_WB     = 0;
    localparam int BIT_TX_EMPTY  = 1;
    localparam int BIT_RX_OVR    = 6;
    localparam int BIT_RX_TIMER  = 7;
    localparam int BIT_MGMT_DONE = 9;

    typedef struct packed {
        logic cause_rd;
        logic cause_set;
        logic mask_set;
        logic mask_clr;
        logic mask_rd;
    } acc_dec_t;
endpackage

// File: rtl/irq_acc_decode.sv
// Decodes one host access into per-register strobes.
// Assumes at most one access per cycle; unmapped offsets yield no strobe.
module irq_acc_decode
    import irq_ctrl_pkg::*;
(
    input  logic                valid,
    input  logic                write,
    input  logic [OFFSET_W-1:0] offset,
    output acc_dec_t            dec
);
    // Purpose: match offset and direction to a strobe
    always_comb begin
        dec           = '0;
        dec.cause_rd  = valid && !write && (offset == OFF_CAUSE_RC);
        dec.cause_set = valid &&  write && (offset == OFF_CAUSE_SET);
        dec.mask_set  = valid &&  write && (offset == OFF_MASK_SET);
        dec.mask_clr  = valid &&  write && (offset == OFF_MASK_CLR);
        dec.mask_rd   = valid && !write && (offset == OFF_MASK_SET);
    end
endmodule

// File: rtl/irq_pend_counter.sv
// Saturating count of receive completions not yet reported to the host.
// Assumes dec_req is the clearing-read strobe; it only counts down from nonzero.
module irq_pend_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec_req,
    output logic nonzero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             dec;

    assign nonzero = (cnt_q != '0);
    assign dec     = dec_req && nonzero;

    // Purpose: count up on completions, down on re-arming reads, saturate at max
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && !dec && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
        else if (dec && !inc)
            cnt_q <= cnt_q - 1'b1;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc && !dec) |=> (cnt_q == CNT_MAX)); // R8
    AST_CNT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9
endmodule

// File: rtl/irq_cause_reg.sv
// Cause register: set by hardware pulses and host writes, cleared by a read.
// Assumes set sources win over the clear so that no event is lost.
module irq_cause_reg #(
    parameter int DATA_W  = 32,
    parameter int REARM_B = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] host_set,
    input  logic [DATA_W-1:0] hw_set,
    input  logic              rx_done,
    input  logic              rearm,
    output logic [DATA_W-1:0] cause_q
);
    localparam logic [DATA_W-1:0] REARM_MASK = DATA_W'(1) << REARM_B;

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] sets;

    // Purpose: form retained bits and all new set sources
    always_comb begin
        keep = clr ? '0 : cause_q;
        sets = host_set | hw_set;
        if (rx_done)
            sets = sets | REARM_MASK;
        if (clr && rearm)
            sets = sets | REARM_MASK;
    end

    // Purpose: register the cause vector
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= '0;
        else
            cause_q <= keep | sets;
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rearm && !rx_done && host_set == '0 && hw_set == '0)
        |=> (cause_q == '0)); // R2
    AST_HOST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_set != '0) |=> ((cause_q & $past(host_set)) == $past(host_set))); // R3
    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((cause_q & $past(hw_set)) == $past(hw_set))); // R7
    AST_REARM_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rearm) |=> cause_q[REARM_B]); // R9
endmodule

// File: rtl/irq_mask_reg.sv
// Mask register with separate set and clear write ports.
// Assumes set and clear never strobe in the same cycle (one access per cycle).
module irq_mask_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q
);
    // Purpose: apply OR-set or AND-NOT-clear to the mask
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_en)
            mask_q <= mask_q | wdata;
        else if (clr_en)
            mask_q <= mask_q & ~wdata;
    end

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask_q & $past(wdata)) == $past(wdata))); // R4
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask_q & $past(wdata)) == '0)); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask_q)); // R10
endmodule

// File: rtl/irq_cause_ctrl.sv
// Top of the interrupt cause/mask controller: decode, cause, mask, pending
// counter, read mux and level interrupt. Assumes single-cycle host accesses.
module irq_cause_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_valid,
    input  logic                host_write,
    input  logic [OFFSET_W-1:0] host_offset,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [DATA_W-1:0]   hw_event_i,
    input  logic                rx_done_i,
    output logic                irq_o
);
    acc_dec_t          dec;
    logic              pend_nz;
    logic [DATA_W-1:0] cause_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] host_set;

    irq_acc_decode i_decode (
        .valid  (host_valid),
        .write  (host_write),
        .offset (host_offset),
        .dec    (dec)
    );

    assign host_set = dec.cause_set ? host_wdata : '0;

    irq_pend_counter #(.CNT_W(CNT_W)) i_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (rx_done_i),
        .dec_req (dec.cause_rd),
        .nonzero (pend_nz)
    );

    irq_cause_reg #(.DATA_W(DATA_W), .REARM_B(BIT_RX_TIMER)) i_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (dec.cause_rd),
        .host_set (host_set),
        .hw_set   (hw_event_i),
        .rx_done  (rx_done_i),
        .rearm    (pend_nz),
        .cause_q  (cause_q)
    );

    irq_mask_reg #(.DATA_W(DATA_W)) i_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (dec.mask_set),
        .clr_en (dec.mask_clr),
        .wdata  (host_wdata),
        .mask_q (mask_q)
    );

    // Purpose: return the addressed register on a read, zero otherwise
    always_comb begin
        host_rdata = '0;
        if (dec.cause_rd)
            host_rdata = cause_q;
        else if (dec.mask_rd)
            host_rdata = mask_q;
    end

    assign irq_o = |(cause_q & mask_q);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (cause_q == '0 && mask_q == '0 && !irq_o)); // R1
endmodule

// File: tb/test_irq_cause_ctrl.sv
module test_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_valid, host_write;
    logic [11:0] host_offset;
    logic [31:0] host_wdata, host_rdata, hw_event_i;
    logic        rx_done_i, irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    irq_cause_ctrl i_irq_cause_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_offset(host_offset), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .hw_event_i(hw_event_i), .rx_done_i(rx_done_i), .irq_o(irq_o)
    );

    typedef struct packed {
        logic        vld;
        logic        wr;
        logic [11:0] off;
        logic [31:0] wd;
        logic [31:0] ev;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,12'h0C0,32'h0,32'h0,32'h0,1'b0,8'd1},         // R1 cause zero
        '{1'b1,1'b0,12'h0D0,32'h0,32'h0,32'h0,1'b0,8'd1},         // R1 mask zero
        '{1'b1,1'b1,12'h0C8,32'h41,32'h0,32'h0,1'b0,8'd3},        // R3 set
        '{1'b1,1'b0,12'h0C0,32'h0,32'h0,32'h41,1'b0,8'd2},        // R2 read
        '{1'b1,1'b0,12'h0C0,32'h0,32'h0,32'h0,1'b0,8'd2},         // R2 cleared
        '{1'b1,1'b1,12'h0D0,32'h201,32'h0,32'h0,1'b0,8'd4},       // R4 set
        '{1'b1,1'b0,12'h0D0,32'h0,32'h0,32'h201,1'b0,8'd4},       // R4 read
        '{1'b1,1'b1,12'h0D0,32'h2,32'h0,32'h0,1'b0,8'd4},         // R4 OR
        '{1'b1,1'b0,12'h0D0,32'h0,32'h0,32'h203,1'b0,8'd4},       // R4
        '{1'b0,1'b0,12'h000,32'h0,32'h200,32'h0,1'b1,8'd7},       // R7 mgmt event, R6
        '{1'b1,1'b1,12'h0D8,32'h200,32'h0,32'h0,1'b0,8'd5},       // R5 clear, R6 drop
        '{1'b1,1'b0,12'h0D0,32'h0,32'h0,32'h3,1'b0,8'd5},         // R5 others kept
        '{1'b1,1'b1,12'h0C8,32'h2,32'h0,32'h0,1'b1,8'd6},         // R6 rise
        '{1'b1,1'b0,12'h0C0,32'h0,32'h0,32'h202,1'b0,8'd6},       // R6 fall on clear
        '{1'b1,1'b1,12'h0C0,32'hFF,32'h0,32'h0,1'b0,8'd10},       // R10 write to read port
        '{1'b1,1'b0,12'h0C0,32'h0,32'h0,32'h0,1'b0,8'd10},        // R10
        '{1'b1,1'b1,12'h0D4,32'hFFFF,32'h0,32'h0,1'b0,8'd10},     // R10 unmapped write
        '{1'b1,1'b0,12'h0D0,32'h0,32'h0,32'h3,1'b0,8'd10},        // R10 mask unchanged
        '{1'b1,1'b1,12'h0C8,32'h1,32'h0,32'h0,1'b1,8'd10},        // set bit0
        '{1'b1,1'b0,12'h0C8,32'h0,32'h0,32'h0,1'b1,8'd10}         // R10 read of set port
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive after negedge, check rdata, check irq after the edge
    task automatic access(input logic vld, input logic wr, input logic [11:0] off,
                          input logic [31:0] wd, input logic [31:0] ev, input logic rx,
                          output logic [31:0] rd);
        @(negedge clk);
        host_valid = vld; host_write = wr; host_offset = off;
        host_wdata = wd; hw_event_i = ev; rx_done_i = rx;
        #1 rd = host_rdata;
        @(posedge clk);
        #1;
        host_valid = 1'b0; hw_event_i = '0; rx_done_i = 1'b0;
    endtask

    logic [31:0] rd;

    initial begin
        host_valid = 0; host_write = 0; host_offset = '0; host_wdata = '0;
        hw_event_i = '0; rx_done_i = 0; rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk("R1", {31'd0, irq_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].vld, VECS[i].wr, VECS[i].off, VECS[i].wd, VECS[i].ev, 1'b0, rd);
            if (VECS[i].vld && !VECS[i].wr)
                chk($sformatf("R%0d rdata vec %0d", VECS[i].req, i), rd, VECS[i].exp_rd);
            chk($sformatf("R%0d irq vec %0d", VECS[i].req, i), {31'd0, irq_o}, {31'd0, VECS[i].exp_irq});
        end
        access(1, 0, 12'h0C0, 0, 0, 0, rd);            // drain bit0

        // R7: event in the same cycle as a clearing read is kept
        access(1, 1, 12'h0C8, 32'h1, 0, 0, rd);
        access(1, 0, 12'h0C0, 0, 32'h40, 0, rd);
        chk("R7 read during event", rd, 32'h1);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R7 event kept", rd, 32'h40);

        // R8/R9: one packet gives two reads with bit 7, then none
        access(1, 1, 12'h0D0, 32'h80, 0, 0, rd);
        access(0, 0, 0, 0, 0, 1, rd);
        chk("R8 irq from rx_done", {31'd0, irq_o}, 32'd1);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R9 first read", rd, 32'h80);
        chk("R9 irq stays armed", {31'd0, irq_o}, 32'd1);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R9 re-armed read", rd, 32'h80);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R9 drained", rd, 32'h0);
        chk("R9 irq low", {31'd0, irq_o}, 32'd0);

        // R8 saturation: 17 pulses into a 15-max counter give 16 reads with bit 7
        for (int k = 0; k < 17; k++) access(0, 0, 0, 0, 0, 1, rd);
        begin
            int hits = 0;
            for (int k = 0; k < 20; k++) begin
                access(1, 0, 12'h0C0, 0, 0, 0, rd);
                if (rd[7]) hits++;
            end
            chk("R8 saturated count", hits, 16);
        end

        // R1: reset in mid-run clears everything
        access(1, 1, 12'h0C8, 32'hF0F0, 0, 0, rd);
        access(0, 0, 0, 0, 0, 1, rd);
        @(negedge clk) rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R1 cause after reset", rd, 32'h0);
        access(1, 0, 12'h0C0, 0, 0, 0, rd);
        chk("R1 counter after reset", rd, 32'h0);
        access(1, 0, 12'h0D0, 0, 0, 0, rd);
        chk("R1 mask after reset", rd, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule